// File: doc/BRIEF.md
# Carry-Skip Adder

This block is a combinational unsigned adder. It takes two operands, which may differ in width, and returns their full sum. The result is one bit wider than the wider operand. Its top bit is the carry-out.

The bit positions are cut into skip groups of `GRP_W` bits, counted from the least significant end. If the width is not a multiple of `GRP_W`, the most significant group holds only the bits that are left over. Inside a group the carry ripples through one-bit adder cells. The lowest cell of the whole adder is a half adder, and every other cell is a full adder.

Each group forms a propagate term per bit as the XOR of the two operand bits, then ANDs those terms together. When every bit of the group propagates, a 2:1 selector passes the group's incoming carry straight to the next group. Otherwise it passes the carry out of the group's top cell. This keeps the long ripple path out of the worst case.

Top module: `carry_skip_adder`

## Requirements
- R1: `result` equals the unsigned sum `opa + opb` for every input pair, at the default widths of 16 and 16 bits with 4-bit groups.
- R2: `result[N]`, the top bit, is 1 exactly when the unsigned sum is at least 2^N. Here N is the wider operand width.
- R3: Groups are formed from bit 0 upward, and a narrower top group is correct. With N=5 and 4-bit groups, all 1024 input pairs give the exact sum.
- R4: When the operand widths differ, N is the larger width and the narrower operand is zero-extended. With a 12-bit `opa` and an 8-bit `opb`, `12'h800 + 8'h80` gives `13'h0880`.
- R5: When every bit of a group has `opa[i] ^ opb[i] = 1`, the group's outgoing carry equals its incoming carry. A carry entering such a group therefore reaches the next group; for example, `16'h00F1 + 16'h000F` gives `17'h00100`.
- R6: When at least one bit of a group does not propagate, the group's outgoing carry is the carry generated by its top cell. For example, `16'h000F + 16'h0001` gives `17'h00010`.
- R7: The adder has no carry input, and the first group's incoming carry is 0. Zero operands give a zero result, and `1 + 0` gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | A_W | First operand, unsigned |
| opb | input | B_W | Second operand, unsigned |
| result | output | N+1 | Sum bits in [N-1:0] and carry-out in [N], where N = max(A_W, B_W) |

## Verification
Within a single evaluation, the skip selector and the ripple chain of one group can both be asked to deliver the same carry. This happens when a group's bits all propagate while a carry is coming in from below. The bench provokes this with directed pairs such as `00F1 + 000F` and `AAAA + 5556`, in which a carry generated in one group has to cross one or more all-propagate groups. The exhaustive 5-bit sweep covers every such overlap in the partial top group as well. Each case is judged by the exact sum at the ports, and the bound checks confirm that the ripple carry and the forwarded carry agree.

// File: rtl/csa_pkg.sv
package csa_pkg;

  function automatic int csa_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int csa_groups(input int n, input int g);
    return (n + g - 1) / g;
  endfunction

  function automatic int csa_grp_width(input int n, input int g, input int idx);
    int rem;
    rem = n - idx * g;
    return (rem < g) ? rem : g;
  endfunction

  function automatic logic csa_sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic csa_carry_bit(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

endpackage

// File: rtl/csa_half.sv
module csa_half
  import csa_pkg::*;
(
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = csa_sum_bit(a, b, 1'b0);
  assign co = csa_carry_bit(a, b, 1'b0);
endmodule

// File: rtl/csa_full.sv
module csa_full
  import csa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = csa_sum_bit(a, b, ci);
  assign co = csa_carry_bit(a, b, ci);
endmodule

// File: rtl/csa_align.sv
module csa_align #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - IN_W;

  generate
    if (PAD > 0) begin : g_pad
      assign dout = {{PAD{1'b0}}, din};
    end else begin : g_same
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         all_prop,
  output logic         ripple,
  output logic         cout
);
  logic [W-1:0] prop;
  logic [W:1]   chain;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0 && FIRST) begin : g_ha
        csa_half u_cell (
          .a  (a[i]),
          .b  (b[i]),
          .s  (sum[i]),
          .co (chain[i+1])
        );
      end else if (i == 0) begin : g_fa_in
        csa_full u_cell (
          .a  (a[i]),
          .b  (b[i]),
          .ci (cin),
          .s  (sum[i]),
          .co (chain[i+1])
        );
      end else begin : g_fa
        csa_full u_cell (
          .a  (a[i]),
          .b  (b[i]),
          .ci (chain[i]),
          .s  (sum[i]),
          .co (chain[i+1])
        );
      end
    end
  endgenerate

  assign prop     = a ^ b;
  assign all_prop = &prop;
  assign ripple   = chain[W];
  assign cout     = all_prop ? cin : ripple;
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder
  import csa_pkg::*;
#(
  parameter  int A_W   = 16,
  parameter  int B_W   = 16,
  parameter  int GRP_W = 4,
  localparam int N     = csa_max(A_W, B_W)
) (
  input  logic [A_W-1:0] opa,
  input  logic [B_W-1:0] opb,
  output logic [N:0]     result
);
  localparam int NGRP = csa_groups(N, GRP_W);

  logic [N-1:0]    a_ext;
  logic [N-1:0]    b_ext;
  logic [N-1:0]    sum_bits;
  logic [NGRP:0]   grp_carry;
  logic [NGRP-1:0] grp_allp;
  logic [NGRP-1:0] grp_rip;

  csa_align #(.IN_W(A_W), .OUT_W(N)) u_align_a (.din(opa), .dout(a_ext));
  csa_align #(.IN_W(B_W), .OUT_W(N)) u_align_b (.din(opb), .dout(b_ext));

  assign grp_carry[0] = 1'b0;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LO = g * GRP_W;
      localparam int GW = csa_grp_width(N, GRP_W, g);
      csa_group #(.W(GW), .FIRST(g == 0)) u_grp (
        .a        (a_ext[LO +: GW]),
        .b        (b_ext[LO +: GW]),
        .cin      (grp_carry[g]),
        .sum      (sum_bits[LO +: GW]),
        .all_prop (grp_allp[g]),
        .ripple   (grp_rip[g]),
        .cout     (grp_carry[g+1])
      );
    end
  endgenerate

  assign result = {grp_carry[NGRP], sum_bits};
endmodule

// File: rtl/csa_chk.sv
module csa_chk
  import csa_pkg::*;
#(
  parameter  int A_W   = 16,
  parameter  int B_W   = 16,
  parameter  int GRP_W = 4,
  localparam int N     = csa_max(A_W, B_W),
  localparam int NGRP  = csa_groups(N, GRP_W),
  localparam int RW    = N + 1
) (
  input logic [A_W-1:0]  opa,
  input logic [B_W-1:0]  opb,
  input logic [N:0]      result,
  input logic [NGRP:0]   grp_carry,
  input logic [NGRP-1:0] grp_allp,
  input logic [NGRP-1:0] grp_rip
);
  logic [N:0]   ref_sum;
  logic [N-1:0] a_z;
  logic [N-1:0] b_z;
  logic [N-1:0] lo_sum;

  assign ref_sum = RW'(opa) + RW'(opb);
  assign a_z     = N'(opa);
  assign b_z     = N'(opb);
  assign lo_sum  = a_z + b_z;

  always_comb begin
    AST_SUM_MATCH: assert (result == ref_sum) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (result[N] == (lo_sum < a_z)) else $error("carry-out wrong"); // R2
    if (opb == '0) begin
      AST_ZERO_EXT: assert (result == RW'(opa)) else $error("extension wrong"); // R4
    end
    for (int g = 0; g < NGRP; g++) begin
      if (grp_allp[g]) begin
        AST_SKIP_FWD: assert (grp_carry[g+1] == grp_carry[g]) else $error("skip wrong"); // R5
        AST_PROP_RIPPLE: assert (grp_rip[g] == grp_carry[g]) else $error("ripple disagrees"); // R5
      end else begin
        AST_RIPPLE_SEL: assert (grp_carry[g+1] == grp_rip[g]) else $error("ripple select wrong"); // R6
      end
    end
  end
endmodule

bind carry_skip_adder csa_chk #(
  .A_W   (A_W),
  .B_W   (B_W),
  .GRP_W (GRP_W)
) u_chk (
  .opa       (opa),
  .opb       (opb),
  .result    (result),
  .grp_carry (grp_carry),
  .grp_allp  (grp_allp),
  .grp_rip   (grp_rip)
);

// File: tb/carry_skip_adder_tb.sv
module carry_skip_adder_tb;
  localparam int WD_LIMIT = 20000;
  localparam int NRAND    = 2000;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [16:0] e;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{16'h0000, 16'h0000, 17'h00000},  // R7
    '{16'hFFFF, 16'h0001, 17'h10000},  // R2
    '{16'hFFFF, 16'hFFFF, 17'h1FFFE},  // R2
    '{16'h000F, 16'h0001, 17'h00010},  // R6
    '{16'hF0F0, 16'h0F0F, 17'h0FFFF},  // R5
    '{16'h00F1, 16'h000F, 17'h00100},  // R5
    '{16'h8000, 16'h8000, 17'h10000},  // R2
    '{16'h1234, 16'h4321, 17'h05555},  // R1
    '{16'hAAAA, 16'h5556, 17'h10000},  // R5
    '{16'h0FFF, 16'hF001, 17'h10000}   // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  logic [15:0] a16, b16;
  logic [16:0] r16;
  logic [4:0]  a5, b5;
  logic [5:0]  r5;
  logic [11:0] am;
  logic [7:0]  bm;
  logic [12:0] rm;

  carry_skip_adder #(.A_W(16), .B_W(16), .GRP_W(4)) u_dut (
    .opa(a16), .opb(b16), .result(r16));
  carry_skip_adder #(.A_W(5), .B_W(5), .GRP_W(4)) u_dut_small (
    .opa(a5), .opb(b5), .result(r5));
  carry_skip_adder #(.A_W(12), .B_W(8), .GRP_W(4)) u_dut_mix (
    .opa(am), .opb(bm), .result(rm));

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a16 = a;
    b16 = b;
    #1;
  endtask

  initial begin
    a16 = '0; b16 = '0; a5 = '0; b5 = '0; am = '0; bm = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset zero result", r16, 17'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      drive16(VEC[i].a, VEC[i].b);
      chk("R1 table vector", r16, VEC[i].e);
    end

    drive16(16'h0001, 16'h0000);
    chk("R7 one plus zero", r16, 17'h1);
    drive16(16'hFFFF, 16'h0000);
    chk("R2 no carry at max", r16, 17'h0FFFF);

    for (int k = 0; k < NRAND; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (k % 8 == 0) rb = ~ra;
      drive16(ra, rb);
      chk("R1 random", r16, {1'b0, ra} + {1'b0, rb});
    end

    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        @(negedge clk);
        a5 = 5'(x);
        b5 = 5'(y);
        #1;
        chk("R3 exhaustive 5-bit", 17'(r5), 17'(x + y));
      end
    end

    @(negedge clk); am = 12'h800; bm = 8'h80; #1;
    chk("R4 zero extend", 17'(rm), 17'h0880);
    @(negedge clk); am = 12'hFFF; bm = 8'hFF; #1;
    chk("R4 extend with carry", 17'(rm), 17'h10FE);
    @(negedge clk); am = 12'h000; bm = 8'hFF; #1;
    chk("R4 narrow only", 17'(rm), 17'h00FF);
    @(negedge clk); am = 12'hF00; bm = 8'h00; #1;
    chk("R4 wide only", 17'(rm), 17'h0F00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule